// File: doc/BRIEF.md
# Six-Output Motor PWM Generator

This block drives the gates of a three-phase motor bridge. One shared up-counter sets the PWM period. The counter runs at the input clock divided by 1, 2, 4 or 8. Each output compares its own active duty value against that counter. The six outputs can work as three complementary pairs or as six separate channels, and each pair has its own polarity inversion.

Software writes period and duty values into staging registers. These are copied into the active compare registers only on a reload strobe. The strobe fires at the end of every first, second, fourth or eighth PWM period. A new reload spacing is held in a staging field and takes effect only when the current period ends. Reads return the staged spacing, not the active one.

While the run input is low, the counters stay at zero and every output sits at its inactive level. The mode bit can only be changed in that state.

Top module: `mpwm_six`

Register map: address 0 is the control register, address 1 is the period, and address 2+i is the duty value of output i. The control register layout is [1:0] prescale, [3:2] reload spacing, [4] separate-channel mode and [7:5] polarity of pairs 0, 1 and 2.

## Requirements
- R1: The reload spacing field, control bits [3:2], sets the number of PWM periods between reload strobes. Codes 00, 01, 10 and 11 give 1, 2, 4 and 8 periods. The strobe is one clock wide and comes in the clock where a period ends.
- R2: A write to the reload spacing field is applied at the end of the PWM period in progress, not at once. Counting towards the next strobe continues from the current reload count.
- R3: Reading control address 0 returns the last value written to the reload spacing field, even before that value is applied.
- R4: In pair mode (control bit 4 = 0), output 2p is high for D counts of each P+1-count period, where D is the duty at address 2+2p and P is the period value. D = 0 gives a constant low output and D ≥ P+1 gives a constant high output. Output 2p+1 is the inverse of output 2p before polarity is applied.
- R5: In separate-channel mode (control bit 4 = 1), output i is high for the duty value at address 2+i counts of each period.
- R6: A write to control bit 4 while run is high is ignored. The other control fields in that write still take effect.
- R7: After reset the control register reads 0x00 and all six outputs are low.
- R8: Control bits [7:5] invert both outputs of pairs 0, 1 and 2 in that order. Pair p drives outputs 2p and 2p+1.
- R9: Control bits [1:0] divide the counting rate by 1, 2, 4 or 8 for codes 00, 01, 10 and 11. The pattern period therefore stretches by that factor.
- R10: While run is low, the counters are held at zero and each output pair is driven to its polarity bit.
- R11: Period and duty writes go to staging registers and reach the outputs only at the next reload strobe. While run is low they are copied continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run | input | 1 | PWM enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | CW | Register read data (combinational) |
| reload_stb | output | 1 | One-clock reload event |
| pwm_out | output | 6 | Outputs; pair p is bits 2p (high side) and 2p+1 |

## Verification
A wrong active reload spacing shows as a changed gap between reload strobes, at the first strobe after the fault. A reload counter that misses the staged change would give a gap of 10 or 80 clocks instead of 20. A wrong period or duty register changes the count of high clocks in one pattern period, which is visible within one period after the next reload. A mode bit that slips while running breaks the complement relation between the two outputs of a pair on the next clock. A counter that is not held while idle shows as outputs that move away from their polarity level.

// File: rtl/mpwm_pkg.sv
`timescale 1ns/1ps
package mpwm_pkg;
  localparam int NPAIR  = 3;
  localparam int NCH    = 2 * NPAIR;
  localparam int A_CTRL = 0;
  localparam int A_PER  = 1;
  localparam int A_DUTY = 2;

  // control register layout, msb first
  typedef struct packed {
    logic [NPAIR-1:0] pol;
    logic             indep;
    logic [1:0]       div;
    logic [1:0]       pres;
  } ctrl_t;
endpackage

// File: rtl/mpwm_regs.sv
`timescale 1ns/1ps
module mpwm_regs
  import mpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [CW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [CW-1:0]          rd_data,
  input  logic                   reload_stb,
  output ctrl_t                  ctrl,
  output logic [CW-1:0]          per_act,
  output logic [NCH-1:0][CW-1:0] duty_act
);
  ctrl_t                  ctrl_q, ctrl_d;
  logic [CW-1:0]          per_stg_q, per_stg_d, per_act_q, per_act_d;
  logic [NCH-1:0][CW-1:0] duty_stg_q, duty_stg_d, duty_act_q, duty_act_d;
  logic                   load_act;

  assign load_act = reload_stb || !run;

  // staging writes; the mode bit is frozen while running
  always_comb begin
    ctrl_d     = ctrl_q;
    per_stg_d  = per_stg_q;
    duty_stg_d = duty_stg_q;
    if (wr_en) begin
      if (wr_addr == AW'(A_CTRL)) begin
        ctrl_d = ctrl_t'(wr_data[7:0]);
        if (run) ctrl_d.indep = ctrl_q.indep;
      end else if (wr_addr == AW'(A_PER)) begin
        per_stg_d = wr_data;
      end else begin
        for (int i = 0; i < NCH; i++)
          if (wr_addr == AW'(A_DUTY + i)) duty_stg_d[i] = wr_data;
      end
    end
  end

  // active compare set follows staging only at reload (or while idle)
  always_comb begin
    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    if (load_act) begin
      per_act_d  = per_stg_q;
      duty_act_d = duty_stg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      per_stg_q  <= '0;
      per_act_q  <= '0;
      duty_stg_q <= '0;
      duty_act_q <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      per_stg_q  <= per_stg_d;
      per_act_q  <= per_act_d;
      duty_stg_q <= duty_stg_d;
      duty_act_q <= duty_act_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_CTRL)) begin
      rd_data = CW'(ctrl_q);
    end else if (rd_addr == AW'(A_PER)) begin
      rd_data = per_stg_q;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (rd_addr == AW'(A_DUTY + i)) rd_data = duty_stg_q[i];
    end
  end

  assign ctrl     = ctrl_q;
  assign per_act  = per_act_q;
  assign duty_act = duty_act_q;

  // R6: mode bit cannot move while the PWM runs
  a_r6_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ctrl_q.indep == $past(ctrl_q.indep));

  // R11: active period only changes on a reload strobe or while idle
  a_r11_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !reload_stb) |=> per_act_q == $past(per_act_q));
endmodule

// File: rtl/mpwm_timebase.sv
`timescale 1ns/1ps
module mpwm_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    pres,
  input  logic [1:0]    div_hold,
  input  logic [CW-1:0] per_act,
  output logic [CW-1:0] cnt,
  output logic          reload_stb
);
  localparam int PW = 3;  // prescale and reload counters reach 7

  logic [PW-1:0] pre_q, pre_d, pre_lim;
  logic [PW-1:0] rl_q, rl_d, rl_lim;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    div_q, div_d;
  logic          tick, wrap, stb;

  assign pre_lim = PW'((4'd1 << pres) - 4'd1);
  assign rl_lim  = PW'((4'd1 << div_q) - 4'd1);
  assign tick    = run && (pre_q >= pre_lim);
  assign wrap    = tick && (cnt_q >= per_act);
  assign stb     = wrap && (rl_q >= rl_lim);

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    rl_d  = rl_q;
    div_d = div_q;
    if (!run) begin
      pre_d = '0;
      cnt_d = '0;
      rl_d  = '0;
      div_d = div_hold;
    end else begin
      pre_d = tick ? '0 : pre_q + PW'(1);
      if (wrap) begin
        cnt_d = '0;
        div_d = div_hold;
        rl_d  = stb ? '0 : rl_q + PW'(1);
      end else if (tick) begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      rl_q  <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      rl_q  <= rl_d;
      div_q <= div_d;
    end
  end

  assign cnt        = cnt_q;
  assign reload_stb = stb;

  // R2: the active spacing only moves on a period boundary
  a_r2_div_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> div_q == $past(div_q));

  // R1: a reload strobe only appears where a period ends
  a_r1_strobe_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    reload_stb |-> (cnt_q >= per_act) && run);

  // R10: counters are held at zero while idle
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0) && (rl_q == '0));

  // R4: counter stays inside the active period
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act);
endmodule

// File: rtl/mpwm_outstage.sv
`timescale 1ns/1ps
module mpwm_outstage
  import mpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   indep,
  input  logic [NPAIR-1:0]       pol,
  input  logic [CW-1:0]          cnt,
  input  logic [NCH-1:0][CW-1:0] duty_act,
  output logic [NCH-1:0]         pwm_out
);
  logic [NCH-1:0] cmp;
  logic [NCH-1:0] out_d, out_q;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign cmp[c] = cnt < duty_act[c];
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic hi, lo;
    always_comb begin
      hi = run && cmp[2*p];
      lo = run && (indep ? cmp[2*p+1] : !cmp[2*p]);
      out_d[2*p]   = hi ^ pol[p];
      out_d[2*p+1] = lo ^ pol[p];
    end

    // R4: in pair mode the two outputs are always opposite while running
    a_r4_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !indep) |=> out_q[2*p] != out_q[2*p+1]);

    // R10: idle level of each pair equals its polarity bit
    a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> out_q[2*p+1 -: 2] == {2{$past(pol[p])}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign pwm_out = out_q;
endmodule

// File: rtl/mpwm_six.sv
`timescale 1ns/1ps
module mpwm_six
  import mpwm_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = $clog2(NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  output logic           reload_stb,
  output logic [NCH-1:0] pwm_out
);
  logic [1:0]             rst_sync;
  logic                   srst_n;
  ctrl_t                  ctrl;
  logic [CW-1:0]          per_act, cnt;
  logic [NCH-1:0][CW-1:0] duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  mpwm_regs #(.CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(srst_n), .run(run),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .reload_stb(reload_stb), .ctrl(ctrl),
    .per_act(per_act), .duty_act(duty_act)
  );

  mpwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(srst_n), .run(run),
    .pres(ctrl.pres), .div_hold(ctrl.div), .per_act(per_act),
    .cnt(cnt), .reload_stb(reload_stb)
  );

  mpwm_outstage #(.CW(CW)) u_out (
    .clk(clk), .rst_n(srst_n), .run(run),
    .indep(ctrl.indep), .pol(ctrl.pol), .cnt(cnt),
    .duty_act(duty_act), .pwm_out(pwm_out)
  );
endmodule

// File: tb/mpwm_six_test.sv
`timescale 1ns/1ps
module mpwm_six_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       reload_stb;
  logic [5:0] pwm_out;

  int checks = 0, fails = 0, cyc = 0;
  int hc[6];
  bit finished = 0;

  mpwm_six uut (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .reload_stb(reload_stb), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic win(input int n);
    for (int c = 0; c < 6; c++) hc[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 6; c++) hc[c] += int'(pwm_out[c]);
    end
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!reload_stb);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d);
    chk(d == 8'h00, "R7 control after reset", d, 0);
    chk(pwm_out == 6'b0, "R7 outputs after reset", pwm_out, 0);
  endtask

  task automatic t_idle_polarity();
    wr(3'd0, 8'hA0);  // pol pair0=1, pair1=0, pair2=1
    idle(2);
    chk(pwm_out == 6'b110011, "R8 idle polarity pattern", pwm_out, 6'b110011);
    wr(3'd0, 8'h00);
    idle(2);
    chk(pwm_out == 6'b000000, "R10 idle level without inversion", pwm_out, 0);
  endtask

  task automatic t_pairs();
    wr(3'd1, 8'd9);
    wr(3'd2, 8'd3);
    wr(3'd4, 8'd0);
    wr(3'd6, 8'd10);
    run = 1'b1;
    idle(20);
    win(10);
    chk(hc[0] == 3, "R4 pair0 high side duty 3", hc[0], 3);
    chk(hc[1] == 7, "R4 pair0 low side inverse", hc[1], 7);
    chk(hc[2] == 0, "R4 duty 0 never high", hc[2], 0);
    chk(hc[3] == 10, "R4 duty 0 low side always high", hc[3], 10);
    chk(hc[4] == 10, "R4 duty P+1 always high", hc[4], 10);
    chk(hc[5] == 0, "R4 duty P+1 low side never high", hc[5], 0);
  endtask

  task automatic t_prescale();
    wr(3'd0, 8'h01);
    idle(25);
    win(20);
    chk(hc[0] == 6, "R9 prescale by 2", hc[0], 6);
    wr(3'd0, 8'h03);
    idle(85);
    win(80);
    chk(hc[0] == 24, "R9 prescale by 8", hc[0], 24);
    wr(3'd0, 8'h00);
    idle(90);
  endtask

  task automatic t_duty_reload();
    wr(3'd2, 8'd7);
    idle(25);
    win(10);
    chk(hc[0] == 7, "R11 new duty after reload", hc[0], 7);
  endtask

  task automatic t_spacing();
    int t0;
    logic [7:0] d;
    wait_stb(); t0 = cyc; wait_stb();
    chk(cyc - t0 == 10, "R1 code 00 gap", cyc - t0, 10);
    wr(3'd0, 8'h08);
    rd(3'd0, d);
    chk(d == 8'h08, "R3 readback of staged spacing", d, 8'h08);
    wait_stb(); wait_stb(); t0 = cyc; wait_stb();
    chk(cyc - t0 == 40, "R1 code 10 gap", cyc - t0, 40);
    wr(3'd0, 8'h0C);
    wait_stb(); wait_stb(); t0 = cyc; wait_stb();
    chk(cyc - t0 == 80, "R1 code 11 gap", cyc - t0, 80);
    // R11: duty staged right after a strobe waits a full reload interval
    wr(3'd2, 8'd2);
    idle(12);
    win(10);
    chk(hc[0] == 7, "R11 duty held until reload", hc[0], 7);
    // R2: switch to code 00 right after a strobe
    wait_stb(); t0 = cyc;
    wr(3'd0, 8'h00);
    rd(3'd0, d);
    chk(d[3:2] == 2'b00, "R3 staged spacing visible at once", d[3:2], 0);
    wait_stb();
    chk(cyc - t0 == 20, "R2 spacing applied at period end", cyc - t0, 20);
    idle(15);
    win(10);
    chk(hc[0] == 2, "R11 staged duty applied", hc[0], 2);
  endtask

  task automatic t_mode_lock();
    logic [7:0] d;
    wr(3'd0, 8'h10);
    rd(3'd0, d);
    chk(d[4] == 1'b0, "R6 mode write ignored while running", d[4], 0);
    idle(3);
    win(10);
    chk(hc[1] == 10 - hc[0], "R6 outputs still complementary", hc[1], 10 - hc[0]);
    run = 1'b0;
    idle(2);
    wr(3'd0, 8'h10);
    rd(3'd0, d);
    chk(d[4] == 1'b1, "R6 mode write accepted while idle", d[4], 1);
  endtask

  task automatic t_independent();
    wr(3'd3, 8'd4);
    run = 1'b1;
    idle(30);
    win(10);
    chk(hc[0] == 2, "R5 output0 own duty", hc[0], 2);
    chk(hc[1] == 4, "R5 output1 own duty", hc[1], 4);
    chk(hc[3] == 0, "R5 output3 own duty 0", hc[3], 0);
    chk(hc[4] == 10, "R5 output4 full duty", hc[4], 10);
  endtask

  task automatic t_run_polarity();
    wr(3'd0, 8'h30);
    idle(3);
    win(10);
    chk(hc[0] == 8, "R8 pair0 inverted high side", hc[0], 8);
    chk(hc[1] == 6, "R8 pair0 inverted low side", hc[1], 6);
    chk(hc[4] == 10, "R8 pair2 untouched", hc[4], 10);
  endtask

  task automatic t_disable();
    int bad = 0;
    run = 1'b0;
    idle(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_out != 6'b000011) bad++;
      if (reload_stb) bad++;
    end
    chk(bad == 0, "R10 outputs parked at polarity level", bad, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_idle_polarity();
    t_pairs();
    t_prescale();
    t_duty_reload();
    t_spacing();
    t_mode_lock();
    t_independent();
    t_run_polarity();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule